// File: doc/BRIEF.md
# Fetch-to-Execute Instruction Queue with Selectable Flush Ordering

This block is a small elastic queue that sits between an instruction fetch stage and an execute stage. Each slot holds one fetched instruction word, the address it was fetched from, and the next address that fetch guessed. Fetch pushes entries through a valid/ready input stream. Execute reads the head through a valid/ready output stream. When execute finds a wrong guess, it raises a flush pulse instead of taking the head.

A push, a pop and a flush may all be presented in the same cycle, and the queue accepts all of them together. A parameter fixes how a flush and a push in the same cycle combine. In the drop-new order, the flush also throws away the entry arriving in that cycle, so the queue is empty afterwards. In the keep-new order, the flush removes only what was already stored, and the arriving entry becomes the only one left. This lets the same block serve a pipeline where fetch is ordered before execute and one where execute is ordered before fetch.

Back-pressure works as follows. An entry is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever a slot is free. When the queue is full, `in_ready` is also high if the head leaves in that same cycle (`out_valid` and `out_ready` both high). The head leaves when `out_valid` and `out_ready` are both high and `flush` is low. `in_ready` depends combinationally on `out_ready`.

Top module: `fetch_flush_queue`

## Requirements
- R1: After reset the queue is empty: `out_valid` is 0 and `in_ready` is 1.
- R2: Entries leave in the order they were accepted, and the instruction, address and predicted-address fields of each entry are unchanged.
- R3: `in_ready` is high exactly when fewer than DEPTH entries are stored, or when the queue holds an entry and `out_ready` is high. The stored count never exceeds DEPTH.
- R4: On a full queue, a same-cycle push and pop are both accepted, and the queue stays full, now holding the new entry at its tail.
- R5: With ORDER = FLUSH_DROPS_NEW (encoding 0), a flush leaves the queue empty on the next cycle, even if an entry was accepted in the flush cycle.
- R6: With ORDER = FLUSH_KEEPS_NEW (encoding 1), a flush together with an accepted push leaves exactly that entry, presented at the head on the next cycle.
- R7: A flush with no accepted push empties the queue on the next cycle, in both orders.
- R8: When flush and a head pop coincide, the flush alone decides the result; the pop has no further effect.
- R9: While `out_valid` is high, `out_ready` is low and no flush occurs, the head fields and `out_valid` hold their values on the next cycle.
- R10: The queue holds exactly DEPTH entries before it stops accepting a lone push (DEPTH = 2 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch offers an entry |
| in_ready | output | 1 | Queue accepts the offered entry this cycle |
| in_instr | input | IW | Instruction word of the offered entry |
| in_pc | input | AW | Address the instruction came from |
| in_ppc | input | AW | Predicted next address |
| out_valid | output | 1 | Head entry present |
| out_ready | input | 1 | Execute takes the head |
| out_instr | output | IW | Head instruction word |
| out_pc | output | AW | Head instruction address |
| out_ppc | output | AW | Head predicted next address |
| flush | input | 1 | Discard the queued entries (misprediction) |

## Verification
On every cycle, the embedded properties check several invariants: the occupancy bound, the empty or single-entry result after a flush in each order, and the stability of a stalled head. Two things can only be shown by the bench's sweeps: that the data and order of the entries survive long mixed push/pop/flush traffic, and that `in_ready` matches the free-slot rule in every combination of inputs. The bench runs both orderings side by side against the same stimulus. This shows the one place where they differ: whether an entry pushed during a flush survives.

// File: rtl/fq_pkg.sv
package fq_pkg;
  typedef enum logic {
    FLUSH_DROPS_NEW = 1'b0,
    FLUSH_KEEPS_NEW = 1'b1
  } flush_order_e;
endpackage

// File: rtl/fq_store.sv
module fq_store #(
  parameter int DEPTH = 2,
  parameter int W     = 64,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [PW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_addr] <= wr_data;
  end

  assign rd_data = slots[rd_addr];
endmodule

// File: rtl/fq_ctrl.sv
module fq_ctrl
  import fq_pkg::*;
#(
  parameter int           DEPTH = 2,
  parameter flush_order_e ORDER = FLUSH_DROPS_NEW,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  output logic          accept,
  output logic          has_head,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic [PW-1:0] rd_addr
);
  logic [PW-1:0] rptr_q, wptr_q, rptr_d, wptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, pop_take, push_fire, pop_fire;
  logic          flush_keeps;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    if (ORDER == FLUSH_KEEPS_NEW) begin : g_keep
      assign flush_keeps = 1'b1;
    end else begin : g_drop
      assign flush_keeps = 1'b0;
    end
  endgenerate

  assign full      = (cnt_q == CW'(DEPTH));
  assign has_head  = (cnt_q != '0);
  assign pop_take  = pop_req && has_head;
  assign accept    = !full || pop_take;
  assign push_fire = push_req && accept;
  assign pop_fire  = pop_take && !flush;

  assign wr_en   = push_fire && (!flush || flush_keeps);
  assign wr_addr = flush ? '0 : wptr_q;
  assign rd_addr = rptr_q;

  always_comb begin
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      rptr_d = '0;
      if (flush_keeps && push_fire) begin
        wptr_d = bump('0);
        cnt_d  = CW'(1);
      end else begin
        wptr_d = '0;
        cnt_d  = '0;
      end
    end else begin
      if (pop_fire)  rptr_d = bump(rptr_q);
      if (push_fire) wptr_d = bump(wptr_q);
      cnt_d = cnt_q + CW'(push_fire) - CW'(pop_fire);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !push_fire) |=> !has_head);

  generate
    if (ORDER == FLUSH_KEEPS_NEW) begin : g_chk_keep
      a_r6_keep_new: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && push_fire) |=> (has_head && cnt_q == CW'(1)));
    end else begin : g_chk_drop
      a_r5_drop_new: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !has_head);
    end
  endgenerate
endmodule

// File: rtl/fetch_flush_queue.sv
module fetch_flush_queue
  import fq_pkg::*;
#(
  parameter int           DEPTH = 2,
  parameter int           IW    = 32,
  parameter int           AW    = 32,
  parameter flush_order_e ORDER = FLUSH_DROPS_NEW,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW = IW + 2 * AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_instr,
  input  logic [AW-1:0] in_pc,
  input  logic [AW-1:0] in_ppc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_instr,
  output logic [AW-1:0] out_pc,
  output logic [AW-1:0] out_ppc,
  input  logic          flush
);
  logic          wr_en;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [EW-1:0] head;

  fq_ctrl #(.DEPTH(DEPTH), .ORDER(ORDER)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (in_valid),
    .pop_req  (out_ready),
    .flush    (flush),
    .accept   (in_ready),
    .has_head (out_valid),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr)
  );

  fq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data ({in_instr, in_pc, in_ppc}),
    .rd_addr (rd_addr),
    .rd_data (head)
  );

  assign {out_instr, out_pc, out_ppc} = head;

  a_r9_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_instr) && $stable(out_pc) && $stable(out_ppc)));
endmodule

// File: tb/sim_fetch_flush_queue.sv
module sim_fetch_flush_queue;
  import fq_pkg::*;
  localparam int D  = 2;
  localparam int IW = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, flush = 1'b0;
  logic [IW-1:0] in_instr = '0;
  logic [AW-1:0] in_pc = '0, in_ppc = '0;

  logic rdy0, val0, rdy1, val1;
  logic [IW-1:0] ins0, ins1;
  logic [AW-1:0] pc0, pc1, pp0, pp1;

  int checks = 0;
  int fails  = 0;
  int seq    = 1;
  logic [95:0] mq0 [$];
  logic [95:0] mq1 [$];

  always #10 clk = ~clk;

  fetch_flush_queue #(.DEPTH(D), .IW(IW), .AW(AW), .ORDER(FLUSH_DROPS_NEW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .in_instr(in_instr), .in_pc(in_pc), .in_ppc(in_ppc),
    .out_valid(val0), .out_ready(out_ready), .out_instr(ins0),
    .out_pc(pc0), .out_ppc(pp0), .flush(flush));

  fetch_flush_queue #(.DEPTH(D), .IW(IW), .AW(AW), .ORDER(FLUSH_KEEPS_NEW)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_instr(in_instr), .in_pc(in_pc), .in_ppc(in_ppc),
    .out_valid(val1), .out_ready(out_ready), .out_instr(ins1),
    .out_pc(pc1), .out_ppc(pp1), .flush(flush));

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare one DUT's outputs with its model queue; sampled mid-cycle
  task automatic cmp(input string req, input int which, input logic rdy,
                     input logic val, input logic [95:0] hd);
    int sz;
    bit er;
    logic [95:0] front;
    sz    = (which == 0) ? mq0.size() : mq1.size();
    front = (sz == 0) ? '0 : ((which == 0) ? mq0[0] : mq1[0]);
    er    = (sz < D) || (out_ready && sz > 0);
    check(rdy == er, {req, " R3 in_ready"}, 96'(rdy), 96'(er));
    check(val == (sz > 0), {req, " out_valid"}, 96'(val), 96'(sz > 0));
    if (sz > 0) check(hd == front, {req, " R2 head"}, hd, front);
  endtask

  // drive one cycle, check both DUTs, then advance the models past the edge
  task automatic cyc(input bit iv, input bit ordy, input bit fl, input string req);
    bit e0, e1, d0, d1;
    @(negedge clk);
    in_valid  = iv;
    out_ready = ordy;
    flush     = fl;
    in_instr  = IW'(32'hA000_0000 + seq);
    in_pc     = AW'(seq * 4);
    in_ppc    = AW'(seq * 4 + 8);
    #1;
    cmp(req, 0, rdy0, val0, {ins0, pc0, pp0});
    cmp(req, 1, rdy1, val1, {ins1, pc1, pp1});
    e0 = iv && ((mq0.size() < D) || (ordy && mq0.size() > 0));
    e1 = iv && ((mq1.size() < D) || (ordy && mq1.size() > 0));
    d0 = ordy && mq0.size() > 0;
    d1 = ordy && mq1.size() > 0;
    @(posedge clk);
    if (fl) begin
      mq0.delete();
      mq1.delete();
      if (e1) mq1.push_back({in_instr, in_pc, in_ppc});
    end else begin
      if (d0) void'(mq0.pop_front());
      if (d1) void'(mq1.pop_front());
      if (e0) mq0.push_back({in_instr, in_pc, in_ppc});
      if (e1) mq1.push_back({in_instr, in_pc, in_ppc});
    end
    if (iv) seq++;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(val0 == 1'b0 && val1 == 1'b0, "R1 out_valid after reset", 96'({val0, val1}), 96'(0));
    check(rdy0 && rdy1, "R1 in_ready after reset", 96'({rdy0, rdy1}), 96'(3));
    rst_n = 1'b1;

    // R10: fill to DEPTH, a lone push is then refused
    cyc(1, 0, 0, "R10 fill");
    cyc(1, 0, 0, "R10 fill");
    cyc(1, 0, 0, "R10 full refuses push");
    // R4: full, push and pop together
    cyc(1, 1, 0, "R4 push+pop on full");
    cyc(0, 0, 0, "R9 head held");
    cyc(0, 0, 0, "R9 head held again");
    // R5/R6: flush with an accepted push
    cyc(1, 1, 1, "R5 R6 flush with push");
    #2;
    check(val0 == 1'b0, "R5 drop-new empty after flush", 96'(val0), 96'(0));
    check(val1 == 1'b1 && ins1 == IW'(32'hA000_0000 + seq - 1),
          "R6 keep-new head is pushed entry", 96'(ins1), 96'(32'hA000_0000 + seq - 1));
    // R7: flush without push
    cyc(1, 0, 0, "R7 refill");
    cyc(0, 0, 1, "R7 flush alone");
    #2;
    check(!val0 && !val1, "R7 both empty", 96'({val0, val1}), 96'(0));
    // R8: flush and pop together
    cyc(1, 0, 0, "R8 fill");
    cyc(1, 0, 0, "R8 fill");
    cyc(0, 1, 1, "R8 flush with pop");
    #2;
    check(!val0 && !val1, "R8 flush dominates pop", 96'({val0, val1}), 96'(0));

    // near-exhaustive sweep of all input combinations across occupancies
    for (int k = 0; k < 4000; k++) begin
      int c;
      c = (k * 5 + k / 8 + k / 61) % 8;
      cyc(c[0], c[1], (c == 6 || c == 7 || (c == 5 && (k % 3 == 0))), "R2 sweep");
    end
    cyc(0, 1, 0, "R2 drain");
    cyc(0, 1, 0, "R2 drain");
    cyc(0, 0, 0, "R2 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule